// File: doc/BRIEF.md
# Polarity-Selectable Phase Detector with Lock Pulse

This block compares a reference comparison clock with a divided-down oscillator feedback clock. Both arrive as plain digital inputs and are sampled on a faster system clock. Each input passes through a synchronizer and a rising-edge detector. A tri-state phase-frequency detector then records which input's edge came first. The block emits a drive code for a tri-state charge-pump pad. The code stays active for as many system cycles as the edges are apart, and is idle (high impedance) otherwise.

A polarity control input picks which input leading the other drives the pad high. An active-low lock pulse is produced alongside the drive pulse and covers exactly the same cycles. When both edges land in the same system cycle, no pulse of either kind is produced, so the resolution limit is one system clock period.

Top module: `edge_phase_comparator`

## Requirements
- R1: With `pol_hi` = 1, a reference rising edge that leads the feedback rising edge by d system cycles (d >= 1) produces drive code 01 (drive high) for exactly d consecutive cycles.
- R2: With `pol_hi` = 1, a feedback rising edge that leads the reference rising edge by d cycles produces drive code 10 (drive low) for exactly d consecutive cycles.
- R3: With `pol_hi` = 0 the sense is inverted: a leading reference edge gives code 10 and a leading feedback edge gives code 01, with the same widths.
- R4: `lock_n` is 0 in exactly those cycles where the drive code is not idle, and 1 in all other cycles.
- R5: Rising edges on both inputs that are sampled in the same system cycle produce no pulse: the drive code stays 00 and `lock_n` stays 1.
- R6: With two synchronizer stages, the drive code leaves idle right after the fourth rising system clock edge that samples the leading input high, and not earlier.
- R7: While `rst_n` is 0 at a clock edge, the drive code becomes 00 and `lock_n` becomes 1. After release with both inputs low, the outputs stay idle until a new rising edge arrives.
- R8: Drive code encoding: 00 idle, 01 drive high, 10 drive low. `pad_oe` is 1 exactly when the code is not 00, and `pad_val` is 1 exactly when the code is 01.
- R9: Only rising edges count. A second rising edge of the leading input before the lagging edge arrives does not restart or end the pulse, and falling edges produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference comparison clock, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| pol_hi | input | 1 | 1: reference leading drives high; 0: inverted |
| drive_code | output | 2 | 00 idle, 01 drive high, 10 drive low |
| pad_oe | output | 1 | Pad output enable, 1 when drive is active |
| pad_val | output | 1 | Pad level when enabled |
| lock_n | output | 1 | Active-low pulse covering the phase error |

## Verification
Two functions can fall in the same system cycle: the arming of one direction flag by its edge and the mutual clear caused by the other input's edge. The table drives edges with zero offset under both polarities to provoke this. Each such case is judged by the requirement that the drive code never leaves idle and `lock_n` never drops. One-cycle offsets in both directions show that the clear leaves a pulse of exactly one cycle.

// File: rtl/epc_pkg.sv
// Package: shared drive-code type for the phase comparator.
// Assumes a two-bit pad drive encoding where 2'b11 is never produced.
package epc_pkg;
    typedef enum logic [1:0] {
        DRV_IDLE = 2'b00,
        DRV_HIGH = 2'b01,
        DRV_LOW  = 2'b10
    } drive_e;
endpackage

// File: rtl/epc_edge_sync.sv
// Module: synchronizes one asynchronous input into the clk domain and
// flags each rising edge with a single-cycle pulse.
// Assumes STAGES >= 2 and inputs that stay high or low for at least
// two clk periods between changes.
module epc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain_q;

    // Shift the input through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], din};
        end
    end

    // Rising edge: newest synchronized sample high, previous low.
    always_comb begin
        rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R9
endmodule

// File: rtl/epc_flag_core.sv
// Module: tri-state phase-frequency flag pair. The rising edge of the
// reference sets the lead flag and the feedback edge sets the lag flag.
// Both clear as soon as both would be set, so edges in the same cycle
// leave both clear.
// Assumes edge inputs are single-cycle pulses in the clk domain.
module epc_flag_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic ref_lead,
    output logic fb_lead
);
    logic ref_nx;
    logic fb_nx;

    // Next flag state: accumulate edges, then cancel when both are set.
    always_comb begin
        ref_nx = ref_lead | ref_rise;
        fb_nx  = fb_lead  | fb_rise;
        if (ref_nx && fb_nx) begin
            ref_nx = 1'b0;
            fb_nx  = 1'b0;
        end
    end

    // Flag registers with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_lead <= 1'b0;
            fb_lead  <= 1'b0;
        end else begin
            ref_lead <= ref_nx;
            fb_lead  <= fb_nx;
        end
    end

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_lead && fb_lead)); // R2
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && fb_rise && !ref_lead && !fb_lead) |=> (!ref_lead && !fb_lead)); // R5
    AST_LEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lead && !fb_rise) |=> ref_lead); // R9
    AST_LEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lead && fb_rise) |=> !ref_lead); // R1
    AST_LEAD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !fb_rise && !fb_lead) |=> ref_lead); // R1
endmodule

// File: rtl/epc_out_shaper.sv
// Module: turns the flag pair and polarity select into a registered
// pad drive code, the pad enable/value pair and the active-low lock pulse.
// Assumes the two flags are never set together.
module epc_out_shaper
    import epc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_lead,
    input  logic       fb_lead,
    input  logic       pol_hi,
    output logic [1:0] drive_code,
    output logic       pad_oe,
    output logic       pad_val,
    output logic       lock_n
);
    drive_e drv_nx;
    drive_e drv_q;

    // Select the drive direction from the leading flag and polarity.
    always_comb begin
        drv_nx = DRV_IDLE;
        if (ref_lead) begin
            drv_nx = pol_hi ? DRV_HIGH : DRV_LOW;
        end else if (fb_lead) begin
            drv_nx = pol_hi ? DRV_LOW : DRV_HIGH;
        end
    end

    // Register the drive code and the lock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q  <= DRV_IDLE;
            lock_n <= 1'b1;
        end else begin
            drv_q  <= drv_nx;
            lock_n <= ~(ref_lead | fb_lead);
        end
    end

    // Map the drive code onto the tri-state pad controls.
    always_comb begin
        drive_code = drv_q;
        pad_oe     = (drv_q != DRV_IDLE);
        pad_val    = (drv_q == DRV_HIGH);
    end

    AST_LOCK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_n == (drv_q == DRV_IDLE)); // R4
    AST_POL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lead && pol_hi) |=> (drv_q == DRV_HIGH)); // R1
    AST_POL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_lead && !pol_hi) |=> (drv_q == DRV_LOW)); // R3
    AST_FB_HIGH_POL: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_lead && pol_hi) |=> (drv_q == DRV_LOW)); // R2
    AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_lead && !fb_lead) |=> (drv_q == DRV_IDLE && lock_n)); // R5
    AST_RST_IDLE: assert property (@(posedge clk)
        !rst_n |=> (drv_q == DRV_IDLE && lock_n)); // R7
endmodule

// File: rtl/edge_phase_comparator.sv
// Module: top of the polarity-selectable phase detector. Synchronizes the
// reference and feedback clocks, detects their rising edges, runs the
// tri-state flag pair and shapes the pad drive and lock pulse.
// Assumes both inputs are much slower than clk; differences below one
// clk period are not resolved.
module edge_phase_comparator #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic       pol_hi,
    output logic [1:0] drive_code,
    output logic       pad_oe,
    output logic       pad_val,
    output logic       lock_n
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_in;
    logic [NCH-1:0] rise_v;
    logic           ref_lead;
    logic           fb_lead;

    // Gather inputs: index 0 reference, index 1 feedback.
    always_comb begin
        raw_in = {fb_in, ref_in};
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
        epc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[ch]),
            .rise (rise_v[ch])
        );
    end

    epc_flag_core u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_rise(rise_v[0]),
        .fb_rise (rise_v[1]),
        .ref_lead(ref_lead),
        .fb_lead (fb_lead)
    );

    epc_out_shaper u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_lead  (ref_lead),
        .fb_lead   (fb_lead),
        .pol_hi    (pol_hi),
        .drive_code(drive_code),
        .pad_oe    (pad_oe),
        .pad_val   (pad_val),
        .lock_n    (lock_n)
    );
endmodule

// File: tb/edge_phase_comparator_bench.sv
module edge_phase_comparator_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic       pol_hi = 1'b1;
    logic [1:0] drive_code;
    logic       pad_oe;
    logic       pad_val;
    logic       lock_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_phase_comparator u_edge_phase_comparator (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .fb_in     (fb_in),
        .pol_hi    (pol_hi),
        .drive_code(drive_code),
        .pad_oe    (pad_oe),
        .pad_val   (pad_val),
        .lock_n    (lock_n)
    );

    // Vector: [15] pol, [14:11] ref cycle, [10:7] fb cycle, [6:5] code, [4:1] width
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 4'd0, 4'd3, 2'b01, 4'd3, 1'b0},  // R1
        {1'b1, 4'd4, 4'd1, 2'b10, 4'd3, 1'b0},  // R2
        {1'b0, 4'd0, 4'd5, 2'b10, 4'd5, 1'b0},  // R3
        {1'b0, 4'd2, 4'd0, 2'b01, 4'd2, 1'b0},  // R3
        {1'b1, 4'd2, 4'd2, 2'b00, 4'd0, 1'b0},  // R5
        {1'b0, 4'd3, 4'd3, 2'b00, 4'd0, 1'b0},  // R5
        {1'b1, 4'd0, 4'd1, 2'b01, 4'd1, 1'b0},  // R1
        {1'b1, 4'd1, 4'd0, 2'b10, 4'd1, 1'b0},  // R2
        {1'b1, 4'd0, 4'd9, 2'b01, 4'd9, 1'b0},  // R1
        {1'b0, 4'd7, 4'd0, 2'b01, 4'd7, 1'b0}   // R3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hit;
        int bad;
        int lockmis;
        int padmis;
        int first;
        // Reset state (R7)
        repeat (3) step();
        check(drive_code == 2'b00, "R7 reset drive", drive_code, 0);
        check(lock_n == 1'b1, "R7 reset lock", lock_n, 1);
        rst_n = 1'b1;
        repeat (4) step();
        check(drive_code == 2'b00 && lock_n, "R7 idle after release", drive_code, 0);

        // Table walk: R1 R2 R3 R4 R5 R8
        for (int v = 0; v < NVEC; v++) begin
            pol_hi = VEC[v][15];
            hit = 0; bad = 0; lockmis = 0; padmis = 0;
            for (int c = 0; c < 24; c++) begin
                if (c == int'(VEC[v][14:11])) ref_in = 1'b1;
                if (c == int'(VEC[v][10:7]))  fb_in  = 1'b1;
                step();
                if (drive_code != 2'b00) begin
                    if (drive_code == VEC[v][6:5]) hit++;
                    else bad++;
                end
                if (lock_n != (drive_code == 2'b00)) lockmis++;
                if (pad_oe != (drive_code != 2'b00) || pad_val != (drive_code == 2'b01)) padmis++;
            end
            check(hit == int'(VEC[v][4:1]), "R1/R2/R3/R5 pulse width", hit, int'(VEC[v][4:1]));
            check(bad == 0, "R1/R2/R3 wrong direction cycles", bad, 0);
            check(lockmis == 0, "R4 lock pulse tracking", lockmis, 0);
            check(padmis == 0, "R8 pad mapping", padmis, 0);
            ref_in = 1'b0;
            fb_in = 1'b0;
            repeat (8) step();
            check(drive_code == 2'b00 && lock_n, "R9 falling edges idle", drive_code, 0);
        end

        // R6 latency: drive leaves idle right after the fourth edge
        pol_hi = 1'b1;
        ref_in = 1'b1;
        first = 0;
        for (int k = 1; k <= 5; k++) begin
            step();
            if (first == 0 && drive_code != 2'b00) first = k;
        end
        check(first == 4, "R6 latency edges", first, 4);
        fb_in = 1'b1;
        repeat (8) step();
        check(drive_code == 2'b00, "R6 pulse ended", drive_code, 0);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (8) step();

        // R9: second leading edge before lagging edge does not disturb pulse
        hit = 0;
        for (int c = 0; c < 24; c++) begin
            if (c == 0) ref_in = 1'b1;
            if (c == 2) ref_in = 1'b0;
            if (c == 4) ref_in = 1'b1;
            if (c == 6) fb_in = 1'b1;
            step();
            if (drive_code == 2'b01) hit++;
        end
        check(hit == 6, "R9 re-edge of leading input", hit, 6);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (8) step();

        // R7: reset in the middle of a pulse
        ref_in = 1'b1;
        repeat (5) step();
        check(drive_code == 2'b01, "R7 pulse before reset", drive_code, 1);
        rst_n = 1'b0;
        ref_in = 1'b0;
        step();
        check(drive_code == 2'b00 && lock_n, "R7 reset clears pulse", drive_code, 0);
        repeat (2) step();
        rst_n = 1'b1;
        bad = 0;
        for (int c = 0; c < 10; c++) begin
            step();
            if (drive_code != 2'b00 || !lock_n) bad++;
        end
        check(bad == 0, "R7 stays idle after reset", bad, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule